// File: doc/BRIEF.md
# Indexed Configuration Register Bank

This block holds a processor's configuration registers behind a pair of I/O ports. Software first writes a register index to the index port. The single access to the data port that follows then reads or writes the selected register. The bank holds four kinds of register: six control bytes, eight address regions of three bytes each, eight region attribute bytes, and two read-only identification bytes. Every stored value is also driven out in parallel, so the rest of the chip can use the settings directly.

The index is consumed by a single data-port access. Any other access drops it as well. A map-enable nibble in the upper half of control byte 3 hides the region, attribute and upper control registers while it holds any value other than 4'b0001. Sequencing is a two-state machine. ST_IDLE means no index is pending and ST_ARMED means one is. The transitions are:

- T_ARM: ST_IDLE to ST_ARMED on an index-port write.
- T_REARM: ST_ARMED to ST_ARMED on another index-port write.
- T_CONSUME: ST_ARMED to ST_IDLE on any data-port access.
- T_DROP: ST_ARMED to ST_IDLE on any other access.

Idle cycles with no strobe keep the state as it is.

Top module: `cfgreg_bank`

## Requirements
- R1: A write to I/O address 0x22 arms the bank, and the written byte becomes the pending index.
- R2: While armed, one access to I/O address 0x23 reads or writes the indexed register, then disarms. A second data access returns 0xFF on read and is dropped on write.
- R3: A data-port access while not armed changes no register, and a read returns 0xFF. io_rdata is 0xFF whenever no register read is taking place.
- R4: The index map is as follows. Control bytes 0 to 3 sit at 0xC0 to 0xC3, and control bytes 4 and 5 at 0xE8 and 0xE9. Region n occupies 0xC4+3n (most significant address byte), 0xC5+3n (next address byte) and 0xC6+3n (size code). Attribute n sits at 0xDC+n. Identification bytes 0 and 1 sit at 0xFE and 0xFF.
- R5: The regions, the attributes and control bytes 4 and 5 are reachable only while control byte 3 bits 7:4 equal 4'b0001. Otherwise writes to them are dropped and reads return 0xFF. Control bytes 0 to 3 are always reachable.
- R6: Identification bytes read 0x31 (index 0xFE) and 0x17 (index 0xFF), and writes to them are dropped. ident_q is {0x17, 0x31}.
- R7: An access to any address other than 0x22 or 0x23 disarms the bank. So does a read of 0x22, which returns 0xFF.
- R8: Indexes not in the map read 0xFF, and writes to them change nothing.
- R9: Reset clears every writable register. ctl_q byte k is control byte k. attr_q byte n is attribute n. rgn_q bits [24n+23:24n] hold region n as {address high, address low, size}.
- R10: An index write while already armed replaces the pending index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the strobe cycle |
| ctl_q | output | 48 | Control bytes 0 to 5 |
| rgn_q | output | 192 | Eight regions, 24 bits each |
| attr_q | output | 64 | Eight attribute bytes |
| ident_q | output | 16 | Identification bytes |

## Verification
The checker watches a set of rules on every cycle. An index write always arms with that byte. Any data-port or foreign access leaves the bank disarmed. io_rdata stays at 0xFF unless an armed data read is under way. Region and attribute contents hold still while the map is off. The bench scenarios cover what those cycle-level rules cannot show. These are the exact placement of each register in the index map, the byte order inside a region, the read-back of stored values, the fixed identification values, and the hiding and reappearance of gated registers as the map-enable nibble changes.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    localparam int BYTE_W    = 8;
    localparam int RGN_BYTES = 3;
    localparam logic [BYTE_W-1:0] IDLE_READ = 8'hFF;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } seq_state_t;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_CTL  = 3'd1,
        K_RGN  = 3'd2,
        K_ATTR = 3'd3,
        K_ID   = 3'd4
    } reg_kind_t;

endpackage

// File: rtl/cfgreg_seq.sv
module cfgreg_seq
    import cfgreg_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IDX_PORT  = 'h22,
    parameter int DATA_PORT = 'h23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic              armed,
    output logic [BYTE_W-1:0] idx_q,
    output logic              data_acc
);

    seq_state_t state, state_nx;
    logic       at_idx, at_data, any_acc, idx_load;

    assign at_idx   = (io_addr == ADDR_W'(IDX_PORT));
    assign at_data  = (io_addr == ADDR_W'(DATA_PORT));
    assign any_acc  = io_rd | io_wr;
    assign idx_load = io_wr & at_idx;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (idx_load) state_nx = ST_ARMED;          // T_ARM
            end
            ST_ARMED: begin
                if (idx_load)     state_nx = ST_ARMED;      // T_REARM
                else if (any_acc) state_nx = ST_IDLE;       // T_CONSUME / T_DROP
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and pending index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx_q <= '0;
        end else begin
            state <= state_nx;
            if (idx_load) idx_q <= io_wdata;
        end
    end

    // outputs
    always_comb begin
        armed    = 1'b0;
        data_acc = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ARMED: begin
                armed    = 1'b1;
                data_acc = any_acc & at_data;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfgreg_decode.sv
module cfgreg_decode
    import cfgreg_pkg::*;
#(
    parameter int N_CTL_OPEN  = 4,
    parameter int N_CTL_GATED = 2,
    parameter int N_RGN       = 8,
    parameter int CTL_BASE    = 'hC0,
    parameter int CTLX_BASE   = 'hE8,
    parameter int RGN_BASE    = 'hC4,
    parameter int ATTR_BASE   = 'hDC,
    parameter int ID_BASE     = 'hFE,
    parameter int SLOT_W      = 3
) (
    input  logic [BYTE_W-1:0] idx,
    output reg_kind_t         kind,
    output logic [SLOT_W-1:0] slot,
    output logic [1:0]        sub,
    output logic              gated
);

    always_comb begin
        int ix;
        int off;
        ix    = int'(idx);
        off   = 0;
        kind  = K_NONE;
        slot  = '0;
        sub   = '0;
        gated = 1'b0;
        if (ix >= CTL_BASE && ix < CTL_BASE + N_CTL_OPEN) begin
            kind = K_CTL;
            slot = SLOT_W'(ix - CTL_BASE);
        end else if (ix >= CTLX_BASE && ix < CTLX_BASE + N_CTL_GATED) begin
            kind  = K_CTL;
            slot  = SLOT_W'(N_CTL_OPEN + ix - CTLX_BASE);
            gated = 1'b1;
        end else if (ix >= RGN_BASE && ix < RGN_BASE + RGN_BYTES * N_RGN) begin
            off   = ix - RGN_BASE;
            kind  = K_RGN;
            slot  = SLOT_W'(off / RGN_BYTES);
            sub   = 2'(off % RGN_BYTES);
            gated = 1'b1;
        end else if (ix >= ATTR_BASE && ix < ATTR_BASE + N_RGN) begin
            kind  = K_ATTR;
            slot  = SLOT_W'(ix - ATTR_BASE);
            gated = 1'b1;
        end else if (ix >= ID_BASE && ix < ID_BASE + 2) begin
            kind = K_ID;
            slot = SLOT_W'(ix - ID_BASE);
        end
    end

endmodule

// File: rtl/cfgreg_store.sv
module cfgreg_store
    import cfgreg_pkg::*;
#(
    parameter int N_CTL  = 6,
    parameter int N_RGN  = 8,
    parameter int SLOT_W = 3,
    parameter logic [7:0] ID0 = 8'h31,
    parameter logic [7:0] ID1 = 8'h17
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  reg_kind_t                 kind,
    input  logic [SLOT_W-1:0]         slot,
    input  logic [1:0]                sub,
    input  logic [BYTE_W-1:0]         wdata,
    output logic [BYTE_W-1:0]         rdata,
    output logic [N_CTL*BYTE_W-1:0]   ctl_q,
    output logic [N_RGN*24-1:0]       rgn_q,
    output logic [N_RGN*BYTE_W-1:0]   attr_q,
    output logic [15:0]               ident_q
);

    logic [BYTE_W-1:0] ctl_r  [N_CTL];
    logic [BYTE_W-1:0] rgn_r  [N_RGN][RGN_BYTES];
    logic [BYTE_W-1:0] attr_r [N_RGN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CTL; i++) ctl_r[i] <= '0;
            for (int i = 0; i < N_RGN; i++) begin
                attr_r[i] <= '0;
                for (int b = 0; b < RGN_BYTES; b++) rgn_r[i][b] <= '0;
            end
        end else if (wr_en) begin
            unique case (kind)
                K_CTL: begin
                    for (int i = 0; i < N_CTL; i++)
                        if (slot == SLOT_W'(i)) ctl_r[i] <= wdata;
                end
                K_RGN: begin
                    for (int i = 0; i < N_RGN; i++)
                        for (int b = 0; b < RGN_BYTES; b++)
                            if (slot == SLOT_W'(i) && sub == 2'(b)) rgn_r[i][b] <= wdata;
                end
                K_ATTR: begin
                    for (int i = 0; i < N_RGN; i++)
                        if (slot == SLOT_W'(i)) attr_r[i] <= wdata;
                end
                K_ID, K_NONE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = IDLE_READ;
        unique case (kind)
            K_CTL: begin
                for (int i = 0; i < N_CTL; i++)
                    if (slot == SLOT_W'(i)) rdata = ctl_r[i];
            end
            K_RGN: begin
                for (int i = 0; i < N_RGN; i++)
                    for (int b = 0; b < RGN_BYTES; b++)
                        if (slot == SLOT_W'(i) && sub == 2'(b)) rdata = rgn_r[i][b];
            end
            K_ATTR: begin
                for (int i = 0; i < N_RGN; i++)
                    if (slot == SLOT_W'(i)) rdata = attr_r[i];
            end
            K_ID: rdata = slot[0] ? ID1 : ID0;
            K_NONE: ;
            default: ;
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < N_CTL; g++) begin : g_ctl
            assign ctl_q[g*BYTE_W +: BYTE_W] = ctl_r[g];
        end
        for (g = 0; g < N_RGN; g++) begin : g_rgn
            assign rgn_q[g*24 +: 24]          = {rgn_r[g][0], rgn_r[g][1], rgn_r[g][2]};
            assign attr_q[g*BYTE_W +: BYTE_W] = attr_r[g];
        end
    endgenerate

    assign ident_q = {ID1, ID0};

endmodule

// File: rtl/cfgreg_bank.sv
module cfgreg_bank
    import cfgreg_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int IDX_PORT    = 'h22,
    parameter int DATA_PORT   = 'h23,
    parameter int N_CTL_OPEN  = 4,
    parameter int N_CTL_GATED = 2,
    parameter int N_RGN       = 8,
    parameter int MAP_REG     = 3,
    parameter logic [3:0] MAP_KEY = 4'b0001,
    parameter logic [7:0] ID0 = 8'h31,
    parameter logic [7:0] ID1 = 8'h17,
    localparam int N_CTL  = N_CTL_OPEN + N_CTL_GATED,
    localparam int SLOT_W = $clog2((N_CTL > N_RGN ? N_CTL : N_RGN) + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic                    io_rd,
    input  logic                    io_wr,
    input  logic [7:0]              io_wdata,
    output logic [7:0]              io_rdata,
    output logic [N_CTL*8-1:0]      ctl_q,
    output logic [N_RGN*24-1:0]     rgn_q,
    output logic [N_RGN*8-1:0]      attr_q,
    output logic [15:0]             ident_q
);

    logic              armed, data_acc, map_on, reachable;
    logic [7:0]        idx_q, store_rdata;
    reg_kind_t         kind;
    logic [SLOT_W-1:0] slot;
    logic [1:0]        sub;
    logic              gated;

    cfgreg_seq #(
        .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .armed(armed), .idx_q(idx_q),
        .data_acc(data_acc)
    );

    cfgreg_decode #(
        .N_CTL_OPEN(N_CTL_OPEN), .N_CTL_GATED(N_CTL_GATED), .N_RGN(N_RGN),
        .SLOT_W(SLOT_W)
    ) u_dec (
        .idx(idx_q), .kind(kind), .slot(slot), .sub(sub), .gated(gated)
    );

    assign map_on    = (ctl_q[MAP_REG*8+4 +: 4] == MAP_KEY);
    assign reachable = (kind != K_NONE) && (!gated || map_on);

    cfgreg_store #(
        .N_CTL(N_CTL), .N_RGN(N_RGN), .SLOT_W(SLOT_W), .ID0(ID0), .ID1(ID1)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(data_acc && io_wr && reachable),
        .kind(kind), .slot(slot), .sub(sub), .wdata(io_wdata),
        .rdata(store_rdata), .ctl_q(ctl_q), .rgn_q(rgn_q), .attr_q(attr_q),
        .ident_q(ident_q)
    );

    assign io_rdata = (data_acc && io_rd && reachable) ? store_rdata : IDLE_READ;

endmodule

// File: rtl/cfgreg_bank_chk.sv
module cfgreg_bank_chk #(
    parameter int ADDR_W    = 16,
    parameter int IDX_PORT  = 'h22,
    parameter int DATA_PORT = 'h23,
    parameter int N_RGN     = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   io_addr,
    input logic                io_rd,
    input logic                io_wr,
    input logic [7:0]          io_wdata,
    input logic [7:0]          io_rdata,
    input logic [N_RGN*24-1:0] rgn_q,
    input logic [N_RGN*8-1:0]  attr_q,
    input logic                armed,
    input logic [7:0]          idx_q,
    input logic                map_on
);

    logic at_idx, at_data;
    assign at_idx  = (io_addr == ADDR_W'(IDX_PORT));
    assign at_data = (io_addr == ADDR_W'(DATA_PORT));

    // R1
    arm_on_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_idx) |=> (armed && idx_q == $past(io_wdata)));

    // R2
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && at_data) |=> !armed);

    // R3
    quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rdata != 8'hFF) |-> (armed && io_rd && at_data));

    // R5
    gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !map_on |=> ($stable(rgn_q) && $stable(attr_q)));

    // R7
    foreign_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && !at_data && !at_idx) |=> !armed);

    // R7
    index_read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && at_idx) |=> !armed);

endmodule

bind cfgreg_bank cfgreg_bank_chk #(
    .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .N_RGN(N_RGN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .rgn_q(rgn_q), .attr_q(attr_q),
    .armed(armed), .idx_q(idx_q), .map_on(map_on)
);

// File: tb/cfgreg_bank_test.sv
`timescale 1ns/1ps
module cfgreg_bank_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  io_addr = '0;
    logic         io_rd = 1'b0;
    logic         io_wr = 1'b0;
    logic [7:0]   io_wdata = '0;
    logic [7:0]   io_rdata;
    logic [47:0]  ctl_q;
    logic [191:0] rgn_q;
    logic [63:0]  attr_q;
    logic [15:0]  ident_q;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    cfgreg_bank uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ctl_q(ctl_q), .rgn_q(rgn_q), .attr_q(attr_q), .ident_q(ident_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare each read strobe against the scoreboard
    always @(negedge clk) begin
        if (io_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard actual=%h expected=none", io_rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                if (io_rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, io_rdata, e);
                end
            end
        end
    end

    task automatic io_op(input logic [15:0] a, input logic w, input logic r, input logic [7:0] d);
        @(posedge clk); #1;
        io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
        @(posedge clk); #1;
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    task automatic arm(input logic [7:0] ix);
        io_op(16'h0022, 1'b1, 1'b0, ix);
    endtask
    task automatic dwr(input logic [7:0] v);
        io_op(16'h0023, 1'b1, 1'b0, v);
    endtask
    task automatic drd(input string tag, input logic [7:0] e);
        exp_q.push_back(e); tag_q.push_back(tag);
        io_op(16'h0023, 1'b0, 1'b1, 8'h00);
    endtask
    task automatic setreg(input logic [7:0] ix, input logic [7:0] v);
        arm(ix); dwr(v);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 ctl reset", ctl_q[31:0], 32'h0);
        chk("R9 rgn reset", rgn_q[31:0], 32'h0);
        chk("R9 attr reset", attr_q[63:32], 32'h0);
        chk("R3 idle rdata", {24'h0, io_rdata}, 32'hFF);
        chk("R6 ident out", {16'h0, ident_q}, 32'h1731);

        // R1 R2 R4 control byte 0 round trip
        arm(8'hC3); drd("R2 ctl3 reset read", 8'h00);
        setreg(8'hC0, 8'h5A);
        arm(8'hC0); drd("R4 ctl0 readback", 8'h5A);
        chk("R9 ctl0 parallel", {24'h0, ctl_q[7:0]}, 32'h5A);

        // R2 one shot: second data access unarmed
        drd("R2 second read", 8'hFF);
        // R3 unarmed write dropped
        dwr(8'h77);
        @(negedge clk);
        chk("R3 unarmed write", {24'h0, ctl_q[7:0]}, 32'h5A);

        // R5 map off: gated region hidden
        setreg(8'hD6, 8'hE0);
        @(negedge clk);
        chk("R5 gated write dropped", rgn_q[6*24 +: 24], 32'h0);
        arm(8'hD6); drd("R5 gated read", 8'hFF);
        setreg(8'hE8, 8'h44);
        @(negedge clk);
        chk("R5 ctl4 gated", {24'h0, ctl_q[39:32]}, 32'h0);

        // R5 map on
        setreg(8'hC3, 8'h10);
        setreg(8'hD6, 8'hE0);
        setreg(8'hD7, 8'h00);
        setreg(8'hD8, 8'h0A);
        setreg(8'hE2, 8'h09);
        setreg(8'hD0, 8'hA0);
        setreg(8'hE8, 8'h33);
        @(negedge clk);
        chk("R4 region6 bytes", {8'h0, rgn_q[6*24 +: 24]}, 32'hE0000A);
        chk("R4 attr6", {24'h0, attr_q[6*8 +: 8]}, 32'h09);
        chk("R4 region4 high", {8'h0, rgn_q[4*24 +: 24]}, 32'hA00000);
        chk("R4 ctl4", {24'h0, ctl_q[39:32]}, 32'h33);
        arm(8'hD8); drd("R4 size readback", 8'h0A);
        arm(8'hE2); drd("R4 attr readback", 8'h09);

        // R6 ident read-only
        setreg(8'hFE, 8'h00);
        arm(8'hFE); drd("R6 ident0", 8'h31);
        arm(8'hFF); drd("R6 ident1", 8'h17);
        @(negedge clk);
        chk("R6 ident after write", {16'h0, ident_q}, 32'h1731);

        // R8 unmapped index
        setreg(8'h40, 8'h55);
        arm(8'h40); drd("R8 unmapped read", 8'hFF);
        @(negedge clk);
        chk("R8 ctl untouched", ctl_q[31:0], 32'h1000005A);

        // R7 foreign port and index read disarm
        arm(8'hC0); io_op(16'h0080, 1'b1, 1'b0, 8'h12);
        drd("R7 after foreign", 8'hFF);
        arm(8'hC0);
        exp_q.push_back(8'hFF); tag_q.push_back("R7 index read");
        io_op(16'h0022, 1'b0, 1'b1, 8'h00);
        drd("R7 after index read", 8'hFF);

        // R10 rearm replaces index
        arm(8'hC0); arm(8'hC3); drd("R10 rearm", 8'h10);

        // R5 nibble other than 0001 hides again
        setreg(8'hC3, 8'h20);
        arm(8'hE2); drd("R5 map off again", 8'hFF);
        setreg(8'hD6, 8'h11);
        @(negedge clk);
        chk("R5 region kept", {8'h0, rgn_q[6*24 +: 24]}, 32'hE0000A);

        repeat (2) @(posedge clk);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule